// File: doc/BRIEF.md
# Tone Presence Guard-Time Validator

This block turns a raw "tone pair detected" indication from a dual-tone frequency detector into registered digits. It stands in for an analog steering timer. A tone is accepted only after the detector has reported it without a break for a programmable present guard time. At that point the 4-bit digit code is captured into a receive register and a receive-full flag is set. A delayed steering flag then follows after a fixed settle delay.

Once a tone has been registered, it counts as ended only after the detector has stayed quiet for a separate absent guard time. A gap shorter than that is treated as a dropout and bridged. The captured digit stays readable until the next validated tone replaces it. Both guard times are counted in ticks of an internal prescaler. The receiver can be held idle by a power-down input or by a call-progress mode input.

Top module: `tone_guard_validator`

## Requirements
- R1: A detect pulse shorter than the present guard time is discarded: `rx_data_o`, `rx_full_o` and `steer_o` are left unchanged.
- R2: When `tone_det_i` stays high for the present guard time, the value on `tone_code_i` is captured into `rx_data_o`. `rx_data_o` changes at no other time.
- R3: `steer_o` is low in the cycle the new code first appears on `rx_data_o`. It rises exactly `SETTLE_CYC` clock cycles later.
- R4: While a tone is held, a low gap on `tone_det_i` shorter than the absent guard time has no effect. `steer_o` stays high, and no new code is captured when detect returns, even if `tone_code_i` has changed.
- R5: A tone ends only after `tone_det_i` has been low for the absent guard time. At that point `steer_o` and `tone_held_o` fall, and `rx_data_o` keeps the last captured code.
- R6: Each capture sets `rx_full_o` in the same cycle `rx_data_o` updates. A one-cycle pulse on `status_rd_i` clears it, and the captured data is not affected.
- R7: While `rx_off_i` or `cp_mode_i` is high, the block is held idle: no capture, `rx_full_o` is not set, and `steer_o` and `tone_held_o` are low within two cycles.
- R8: The present and absent guard times are separate inputs. Shortening one changes only its own decision. `tone_held_o` is high from capture until the tone ends.
- R9: Guard times are counted in prescaler ticks of `TICK_DIV` clock cycles each. With a guard of G ticks, a pulse shorter than (G-1)*`TICK_DIV`+1 cycles is never accepted.
- R10: After reset, `rx_data_o` is 0 and `steer_o`, `tone_held_o` and `rx_full_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tone_det_i | input | 1 | Early indication that a valid tone pair is present |
| tone_code_i | input | CODE_W | Digit code decoded from the current tone pair |
| rx_off_i | input | 1 | Receiver powered down; holds the block idle |
| cp_mode_i | input | 1 | Call-progress mode selected; holds the block idle |
| present_guard_i | input | CNT_W | Present guard time in prescaler ticks |
| absent_guard_i | input | CNT_W | Absent guard time in prescaler ticks |
| status_rd_i | input | 1 | Status read strobe; clears the receive-full flag |
| rx_data_o | output | CODE_W | Last captured digit code |
| steer_o | output | 1 | Delayed steering flag |
| tone_held_o | output | 1 | A registered tone is currently in effect (guard output) |
| rx_full_o | output | 1 | New digit captured and not yet acknowledged |

## Verification
The bench drives detect bursts on both sides of the present guard: a 20-cycle burst against a 10-tick guard, then the same burst against a 3-tick guard. This separates rejection from acceptance and shows that the present guard is a live input. Inside a held tone it opens a gap shorter than the absent guard and changes the code during it, which separates a bridged dropout from a new registration. The same gap with a shortened absent guard must end the tone. A 16-cycle burst against a 6-tick guard separates tick-based counting from cycle-based counting. Call-progress mode and power-down are applied both before a tone and during a held tone, to separate blocked capture from a forced end.

// File: rtl/tgv_pkg.sv
package tgv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_QUAL_P = 2'd1,
    ST_HELD   = 2'd2,
    ST_QUAL_A = 2'd3
  } tgv_state_e;
endpackage

// File: rtl/tgv_tick_gen.sv
module tgv_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = wrap;

  always_comb begin
    if (wrap) div_d = '0;
    else      div_d = div_q + DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end
endmodule

// File: rtl/tgv_guard_timer.sv
module tgv_guard_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = run_i && (cnt_q >= limit_i);
  assign cnt_en = !run_i || (tick_i && (cnt_q < limit_i));

  always_comb begin
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TIMER_ONE_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> (cnt_q == $past(cnt_q)) || !$past(run_i)); // R9
  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/tgv_fsm.sv
module tgv_fsm
  import tgv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       det_i,
  input  logic       enable_i,
  input  logic       pres_done_i,
  input  logic       abs_done_i,
  output logic       pres_run_o,
  output logic       abs_run_o,
  output logic       latch_o,
  output logic       held_next_o
);
  tgv_state_e state_q, state_d;

  assign pres_run_o  = (state_q == ST_QUAL_P) && det_i && enable_i;
  assign abs_run_o   = (state_q == ST_QUAL_A) && !det_i && enable_i;
  assign latch_o     = pres_run_o && pres_done_i;
  assign held_next_o = (state_d == ST_HELD) || (state_d == ST_QUAL_A);

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (det_i) state_d = ST_QUAL_P;
        ST_QUAL_P: begin
          if (!det_i)          state_d = ST_IDLE;
          else if (pres_done_i) state_d = ST_HELD;
        end
        ST_HELD:   if (!det_i) state_d = ST_QUAL_A;
        ST_QUAL_A: begin
          if (det_i)           state_d = ST_HELD;
          else if (abs_done_i) state_d = ST_IDLE;
        end
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_SHORT_BURST_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL_P) && !det_i |=> state_q == ST_IDLE); // R1
  AST_DROPOUT_BRIDGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL_A) && det_i && enable_i |=> state_q == ST_HELD); // R4
  AST_END_NEEDS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL_A) && enable_i && !abs_done_i |=> state_q != ST_IDLE); // R5
  AST_FORCED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> state_q == ST_IDLE); // R7
endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 8,
  parameter int TICK_DIV   = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tone_det_i,
  input  logic [CODE_W-1:0] tone_code_i,
  input  logic              rx_off_i,
  input  logic              cp_mode_i,
  input  logic [CNT_W-1:0]  present_guard_i,
  input  logic [CNT_W-1:0]  absent_guard_i,
  input  logic              status_rd_i,
  output logic [CODE_W-1:0] rx_data_o,
  output logic              steer_o,
  output logic              tone_held_o,
  output logic              rx_full_o
);
  localparam int PW = (SETTLE_CYC > 0) ? SETTLE_CYC : 1;

  logic tick, enable;
  logic pres_run, abs_run, pres_done, abs_done;
  logic latch, held_next;

  logic [CODE_W-1:0] data_q;
  logic [PW-1:0]     pipe_q, pipe_d;
  logic              steer_q, steer_d;
  logic              full_q, full_d;
  logic              held_q;

  assign enable = !rx_off_i && !cp_mode_i;

  tgv_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  tgv_guard_timer #(.CNT_W(CNT_W)) u_pres_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .run_i  (pres_run),
    .limit_i(present_guard_i),
    .done_o (pres_done)
  );

  tgv_guard_timer #(.CNT_W(CNT_W)) u_abs_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .run_i  (abs_run),
    .limit_i(absent_guard_i),
    .done_o (abs_done)
  );

  tgv_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (tone_det_i),
    .enable_i   (enable),
    .pres_done_i(pres_done),
    .abs_done_i (abs_done),
    .pres_run_o (pres_run),
    .abs_run_o  (abs_run),
    .latch_o    (latch),
    .held_next_o(held_next)
  );

  // Settle delay line between capture and the steering flag
  generate
    if (SETTLE_CYC > 0) begin : g_settle
      always_comb begin
        pipe_d[0] = latch && held_next;
        for (int i = 1; i < PW; i++) pipe_d[i] = pipe_q[i-1] && held_next;
      end
      always_comb steer_d = held_next && (steer_q || pipe_q[PW-1]);
    end else begin : g_nosettle
      always_comb pipe_d = '0;
      always_comb steer_d = held_next && (steer_q || latch);
    end
  endgenerate

  always_comb begin
    full_d = full_q;
    if (latch)            full_d = 1'b1;
    else if (status_rd_i) full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      pipe_q  <= '0;
      steer_q <= 1'b0;
      full_q  <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      if (latch) data_q <= tone_code_i;
      pipe_q  <= pipe_d;
      steer_q <= steer_d;
      full_q  <= full_d;
      held_q  <= held_next;
    end
  end

  assign rx_data_o   = data_q;
  assign steer_o     = steer_q;
  assign tone_held_o = held_q;
  assign rx_full_o   = full_q;

  AST_DATA_ONLY_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> $past(latch)); // R2
  AST_FULL_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> full_q); // R6
  AST_STEER_WITHIN_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_q |-> held_q); // R5
  AST_NO_STEER_AT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> !steer_q); // R3
endmodule

// File: tb/tone_guard_validator_bench.sv
module tone_guard_validator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NW = 8;
  localparam int DIV = 4;
  localparam int SETTLE = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          det, off, cp, rd;
  logic [CW-1:0] code;
  logic [NW-1:0] pg, ag;
  logic [CW-1:0] data;
  logic          steer, held, full;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_guard_validator #(
    .CODE_W(CW), .CNT_W(NW), .TICK_DIV(DIV), .SETTLE_CYC(SETTLE)
  ) u_tone_guard_validator (
    .clk_i(clk), .rst_ni(rst_n), .tone_det_i(det), .tone_code_i(code),
    .rx_off_i(off), .cp_mode_i(cp), .present_guard_i(pg), .absent_guard_i(ag),
    .status_rd_i(rd), .rx_data_o(data), .steer_o(steer), .tone_held_o(held),
    .rx_full_o(full)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic status_read();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "data after reset", data, 0);
    chk("R10", "steer after reset", steer, 0);
    chk("R10", "held after reset", held, 0);
    chk("R10", "full after reset", full, 0);
  endtask

  task automatic t_short_burst();
    code = 4'd5; det = 1'b1; cyc(20); det = 1'b0; cyc(60);
    chk("R1", "data after short burst", data, 0);
    chk("R1", "full after short burst", full, 0);
    chk("R1", "steer after short burst", steer, 0);
  endtask

  task automatic t_register();
    int n = 0;
    int m = 0;
    code = 4'd9; det = 1'b1;
    while (data != 4'd9 && n < 100) begin cyc(1); n++; end
    chk("R2", "captured code", data, 9);
    chk("R6", "full at capture", full, 1);
    chk("R3", "steer low at capture", steer, 0);
    chk("R8", "held at capture", held, 1);
    while (!steer && m < 20) begin cyc(1); m++; end
    chk("R3", "settle cycles", m, SETTLE);
    cyc(40); det = 1'b0; cyc(80);
    chk("R5", "steer after tone end", steer, 0);
    chk("R5", "held after tone end", held, 0);
    chk("R5", "data kept after end", data, 9);
  endtask

  task automatic t_status_read();
    status_read();
    chk("R6", "full after status read", full, 0);
    chk("R6", "data after status read", data, 9);
  endtask

  task automatic t_dropout();
    code = 4'd3; det = 1'b1; cyc(80);
    chk("R2", "second capture", data, 3);
    status_read();
    det = 1'b0; cyc(16); code = 4'd7; det = 1'b1; cyc(8);
    chk("R4", "steer across dropout", steer, 1);
    chk("R4", "data across dropout", data, 3);
    chk("R4", "no new full after dropout", full, 0);
    det = 1'b0; cyc(80);
    chk("R5", "steer after long gap", steer, 0);
  endtask

  task automatic t_disable();
    cp = 1'b1; code = 4'd12; det = 1'b1; cyc(80);
    chk("R7", "no capture in cp mode", data, 3);
    chk("R7", "no full in cp mode", full, 0);
    chk("R7", "not held in cp mode", held, 0);
    det = 1'b0; cp = 1'b0; cyc(60);
    code = 4'd4; det = 1'b1; cyc(80);
    chk("R2", "capture before power-down", data, 4);
    off = 1'b1; cyc(2);
    chk("R7", "steer dropped by power-down", steer, 0);
    chk("R7", "held dropped by power-down", held, 0);
    det = 1'b0; off = 1'b0; status_read(); cyc(60);
  endtask

  task automatic t_guards();
    pg = 8'd3; code = 4'd1; det = 1'b1; cyc(20); det = 1'b0; cyc(60);
    chk("R8", "short guard accepts 20-cycle burst", data, 1);
    pg = 8'd6; code = 4'd2; det = 1'b1; cyc(16); det = 1'b0; cyc(60);
    chk("R9", "16 cycles under 6-tick guard rejected", data, 1);
    det = 1'b1; cyc(40); det = 1'b0; cyc(60);
    chk("R9", "40 cycles under 6-tick guard accepted", data, 2);
    pg = 8'd10; ag = 8'd2; code = 4'd6; det = 1'b1; cyc(80);
    chk("R8", "steer before gap", steer, 1);
    det = 1'b0; cyc(16); det = 1'b1; cyc(2);
    chk("R8", "short absent guard ends tone", steer, 0);
    det = 1'b0; cyc(60);
  endtask

  initial begin
    rst_n = 1'b0; det = 1'b0; off = 1'b0; cp = 1'b0; rd = 1'b0;
    code = '0; pg = 8'd10; ag = 8'd10;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_short_burst();
    t_register();
    t_status_read();
    t_dropout();
    t_disable();
    t_guards();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule